// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block is a register-mapped controller for up to 64 switchable power domains. Software asks for a domain to be switched on or off by writing a command register that belongs to that domain. One shared sequencer works through each accepted request. A fixed, parameterised number of clock cycles stands in for the settling time of a power switch. While the sequencer is working, the global ready field drops. Any command that arrives during that time is refused, and the refusal is recorded in a per-domain error bit, so software must submit the request again once the controller is ready.

When a sequence ends, or when a request asks for the state the domain is already in, the controller records a per-domain completion flag. The flag is recorded only if its enable bit is set. It stays set until software writes a 1 to it. A mask bit keeps a recorded flag away from the interrupt output without removing the flag. Live state can be read per domain, and also as packed on and off words that carry one bit per domain.

Top module: `pdsc_top`

## Requirements
- R1: After reset, every domain is off: its state register reads 0x0000_0001, its `pd_on` bit is low, and its bit in the off-status word is 1. The ready field reads 2'b11. All flag, enable and mask words read 0, and `irq` is low.
- R2: Bits [1:0] of the global status register at 0x000 read 2'b11 while no sequence runs, and 2'b00 from the cycle after a request is accepted until the sequence ends.
- R3: Domain n has a bank at 0x1000 + n*0x40. A write with bit 0 = 1 to +0x4 requests power-on, and the same write to +0x8 requests power-off. A command write with bit 0 = 0 has no effect.
- R4: The state register at +0x0 of a domain reads as follows: bit 0 = off, bit 4 = on, bit 8 = an off sequence is running, bit 12 = an on sequence is running. All other bits read 0.
- R5: An accepted request that changes a domain's state completes exactly SEQ_CYCLES clock edges after the edge that accepted it. The domain's state and the ready field change on that same edge.
- R6: A command written while a sequence runs is refused. The target domain's state does not change, the running sequence is not disturbed, and bit 0 of the error register at +0xC is set. The next request that is accepted for that domain clears the bit.
- R7: A request for the state the domain is already in completes on the accepting edge. It records the flag and never drops the ready field.
- R8: The on-status word x at 0x800 + 4x and the off-status word x at 0x808 + 4x each hold domain n at bit n mod 32 of word n div 32. A bit is set only when the domain has settled in that state.
- R9: Flag word x at 0x810 + 4x records a completion only when the matching bit of enable word x at 0x820 + 4x is set. Writing 1 to a flag bit clears it. Writing 0 to a flag bit has no effect.
- R10: `irq` is the OR over all domains of flag AND enable AND NOT mask, with mask word x at 0x830 + 4x. A masked flag stays recorded.
- R11: `pd_on[n]` is high exactly while domain n is powered. It changes only on a completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears after the next edge |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered and held between reads |
| irq | output | 1 | Level interrupt from unmasked, enabled flags |
| pd_on | output | NUM_DOMAINS | Power-enable level for each domain |

## Verification
A corrupted sequencer count shows up as the ready field returning too early or too late, so reads of the global status word taken on the edges just before and just after the expected completion separate a correct design from a faulty one within one cycle. A wrong domain index or direction latched at acceptance shows up on the next state read as a progress bit on the wrong domain, and SEQ_CYCLES later as a wrong `pd_on` bit or a wrong on/off status word. Faults in the flag logic, such as a set that ignores the enable bit, a clear that ignores the written data, or a lost mask, are visible on the first flag read or `irq` sample after the write or completion that caused them.

// File: rtl/pdsc_pkg.sv
package pdsc_pkg;

    localparam int REG_W = 32;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_GSR,
        RK_ONSTAT,
        RK_OFFSTAT,
        RK_FLAG,
        RK_ENA,
        RK_MASK,
        RK_DSTATE,
        RK_DON,
        RK_DOFF,
        RK_DERR
    } reg_kind_e;

    localparam logic [15:0] GROUP_BASE = 16'h0800;
    localparam logic [15:0] BANK_BASE  = 16'h1000;
    localparam int          BANK_SHIFT = 6;

    localparam int ST_OFF_BIT    = 0;
    localparam int ST_ON_BIT     = 4;
    localparam int ST_GOOFF_BIT  = 8;
    localparam int ST_GOON_BIT   = 12;

endpackage

// File: rtl/pdsc_decode.sv
module pdsc_decode
    import pdsc_pkg::*;
#(
    parameter int NUM_DOMAINS = 64,
    parameter int ADDR_W      = 16,
    parameter int IDX_W       = 6,
    parameter int NW          = 2,
    parameter int WIDX_W      = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  dom,
    output logic [WIDX_W-1:0] word
);

    localparam logic [ADDR_W-1:0] GRP_A  = ADDR_W'(GROUP_BASE);
    localparam logic [ADDR_W-1:0] BANK_A = ADDR_W'(BANK_BASE);
    localparam logic [ADDR_W-1:0] N_A    = ADDR_W'(NUM_DOMAINS);
    localparam logic [1:0]        NW_A   = 2'(NW);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] dom_full;
    logic [1:0]        word_full;

    always_comb begin
        rel       = addr - BANK_A;
        dom_full  = rel >> BANK_SHIFT;
        word_full = 2'b00;
        kind      = RK_NONE;
        if (addr == '0) begin
            kind = RK_GSR;
        end else if ((addr >> 6) == (GRP_A >> 6) && addr[1:0] == 2'b00) begin
            unique case (addr[5:4])
                2'd0: begin
                    word_full = {1'b0, addr[2]};
                    kind      = addr[3] ? RK_OFFSTAT : RK_ONSTAT;
                end
                2'd1: begin word_full = addr[3:2]; kind = RK_FLAG; end
                2'd2: begin word_full = addr[3:2]; kind = RK_ENA;  end
                default: begin word_full = addr[3:2]; kind = RK_MASK; end
            endcase
            if (word_full >= NW_A) kind = RK_NONE;
        end else if (addr >= BANK_A && dom_full < N_A) begin
            unique case (addr[5:0])
                6'h00:   kind = RK_DSTATE;
                6'h04:   kind = RK_DON;
                6'h08:   kind = RK_DOFF;
                6'h0C:   kind = RK_DERR;
                default: kind = RK_NONE;
            endcase
        end
        dom  = dom_full[IDX_W-1:0];
        word = word_full[WIDX_W-1:0];
    end

endmodule

// File: rtl/pdsc_seq.sv
module pdsc_seq #(
    parameter int NUM_DOMAINS = 64,
    parameter int SEQ_CYCLES  = 8,
    parameter int IDX_W       = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_on,
    input  logic [IDX_W-1:0]       req_idx,
    output logic                   busy,
    output logic                   cur_on,
    output logic [IDX_W-1:0]       cur_idx,
    output logic [NUM_DOMAINS-1:0] on_vec,
    output logic [NUM_DOMAINS-1:0] err_vec,
    output logic                   done_v,
    output logic [IDX_W-1:0]       done_idx
);

    localparam int CNT_W = (SEQ_CYCLES > 1) ? $clog2(SEQ_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SEQ_CYCLES - 1);

    typedef struct packed {
        logic                   busy;
        logic                   dir_on;
        logic [IDX_W-1:0]       idx;
        logic [CNT_W-1:0]       cnt;
        logic [NUM_DOMAINS-1:0] on;
        logic [NUM_DOMAINS-1:0] err;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d    = seq_q;
        done_v   = 1'b0;
        done_idx = seq_q.idx;
        if (seq_q.busy) begin
            if (seq_q.cnt == '0) begin
                seq_d.busy             = 1'b0;
                seq_d.on[seq_q.idx]    = seq_q.dir_on;
                done_v                 = 1'b1;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
        if (req_valid) begin
            if (seq_q.busy) begin
                seq_d.err[req_idx] = 1'b1;
            end else begin
                seq_d.err[req_idx] = 1'b0;
                if (seq_q.on[req_idx] == req_on) begin
                    done_v   = 1'b1;
                    done_idx = req_idx;
                end else begin
                    seq_d.busy   = 1'b1;
                    seq_d.dir_on = req_on;
                    seq_d.idx    = req_idx;
                    seq_d.cnt    = CNT_LOAD;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy    = seq_q.busy;
    assign cur_on  = seq_q.dir_on;
    assign cur_idx = seq_q.idx;
    assign on_vec  = seq_q.on;
    assign err_vec = seq_q.err;

    p_seq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy && seq_q.cnt != '0 |=> seq_q.busy && $stable(seq_q.idx) && $stable(seq_q.dir_on));

    p_refuse_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && seq_q.busy |=> seq_q.err[$past(req_idx)]);

    p_same_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !seq_q.busy && (seq_q.on[req_idx] == req_on) |=> !seq_q.busy);

    p_on_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.busy && !req_valid |=> $stable(seq_q.on));

endmodule

// File: rtl/pdsc_irq.sv
module pdsc_irq
    import pdsc_pkg::*;
#(
    parameter int NUM_DOMAINS = 64,
    parameter int NW          = 2,
    parameter int IDX_W       = 6,
    parameter int WIDX_W      = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_kind_e          wr_kind,
    input  logic [WIDX_W-1:0]  wr_word,
    input  logic [REG_W-1:0]   wdata,
    input  logic               done_v,
    input  logic [IDX_W-1:0]   done_idx,
    output logic [NW*32-1:0]   flag_flat,
    output logic [NW*32-1:0]   ena_flat,
    output logic [NW*32-1:0]   mask_flat,
    output logic               irq
);

    typedef struct packed {
        logic [NW*32-1:0] flag;
        logic [NW*32-1:0] ena;
        logic [NW*32-1:0] mask;
    } irq_t;

    irq_t irq_q, irq_d;

    function automatic logic [31:0] live_bits(input int w);
        logic [31:0] m;
        for (int b = 0; b < 32; b++) m[b] = ((w * 32 + b) < NUM_DOMAINS);
        return m;
    endfunction

    logic wr_flag;
    assign wr_flag = wr_en && (wr_kind == RK_FLAG);

    always_comb begin
        irq_d = irq_q;
        if (wr_en) begin
            unique case (wr_kind)
                RK_FLAG: irq_d.flag[int'(wr_word)*32 +: 32] =
                             irq_q.flag[int'(wr_word)*32 +: 32] & ~wdata;
                RK_ENA:  irq_d.ena[int'(wr_word)*32 +: 32] =
                             wdata & live_bits(int'(wr_word));
                RK_MASK: irq_d.mask[int'(wr_word)*32 +: 32] =
                             wdata & live_bits(int'(wr_word));
                default: ;
            endcase
        end
        if (done_v && irq_q.ena[done_idx]) irq_d.flag[done_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign flag_flat = irq_q.flag;
    assign ena_flat  = irq_q.ena;
    assign mask_flat = irq_q.mask;
    assign irq       = |(irq_q.flag & irq_q.ena & ~irq_q.mask);

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_v && irq_q.ena[done_idx] |=> irq_q.flag[$past(done_idx)]);

    p_flag_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_v && !irq_q.ena[done_idx] && !wr_flag
        |=> irq_q.flag[$past(done_idx)] == $past(irq_q.flag[done_idx]));

endmodule

// File: rtl/pdsc_top.sv
module pdsc_top
    import pdsc_pkg::*;
#(
    parameter int NUM_DOMAINS = 64,
    parameter int SEQ_CYCLES  = 8,
    parameter int ADDR_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    output logic [31:0]            rdata,
    output logic                   irq,
    output logic [NUM_DOMAINS-1:0] pd_on
);

    localparam int IDX_W  = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1;
    localparam int NW     = (NUM_DOMAINS + 31) / 32;
    localparam int WIDX_W = (NW > 1) ? $clog2(NW) : 1;

    reg_kind_e          kind;
    logic [IDX_W-1:0]   dom;
    logic [WIDX_W-1:0]  word;

    logic                   req_valid, req_on;
    logic                   seq_busy, seq_dir_on, done_v;
    logic [IDX_W-1:0]       seq_idx, done_idx;
    logic [NUM_DOMAINS-1:0] on_vec, err_vec;
    logic [NW*32-1:0]       flag_flat, ena_flat, mask_flat;
    logic [NW*32-1:0]       on_set, off_set;
    logic [NUM_DOMAINS-1:0] moving;

    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    rd_t rd_q, rd_d;

    pdsc_decode #(
        .NUM_DOMAINS(NUM_DOMAINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .NW(NW), .WIDX_W(WIDX_W)
    ) u_dec (
        .addr(addr), .kind(kind), .dom(dom), .word(word)
    );

    assign req_valid = wr_en && (kind == RK_DON || kind == RK_DOFF) && wdata[0];
    assign req_on    = (kind == RK_DON);

    pdsc_seq #(
        .NUM_DOMAINS(NUM_DOMAINS), .SEQ_CYCLES(SEQ_CYCLES), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_on(req_on), .req_idx(dom),
        .busy(seq_busy), .cur_on(seq_dir_on), .cur_idx(seq_idx),
        .on_vec(on_vec), .err_vec(err_vec),
        .done_v(done_v), .done_idx(done_idx)
    );

    pdsc_irq #(
        .NUM_DOMAINS(NUM_DOMAINS), .NW(NW), .IDX_W(IDX_W), .WIDX_W(WIDX_W)
    ) u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_kind(kind), .wr_word(word), .wdata(wdata),
        .done_v(done_v), .done_idx(done_idx),
        .flag_flat(flag_flat), .ena_flat(ena_flat), .mask_flat(mask_flat),
        .irq(irq)
    );

    always_comb begin
        on_set  = '0;
        off_set = '0;
        for (int i = 0; i < NUM_DOMAINS; i++) begin
            moving[i]  = seq_busy && (seq_idx == IDX_W'(i));
            on_set[i]  = on_vec[i] && !moving[i];
            off_set[i] = !on_vec[i] && !moving[i];
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.rdata = '0;
            unique case (kind)
                RK_GSR:     rd_d.rdata[1:0] = seq_busy ? 2'b00 : 2'b11;
                RK_ONSTAT:  rd_d.rdata = on_set[int'(word)*32 +: 32];
                RK_OFFSTAT: rd_d.rdata = off_set[int'(word)*32 +: 32];
                RK_FLAG:    rd_d.rdata = flag_flat[int'(word)*32 +: 32];
                RK_ENA:     rd_d.rdata = ena_flat[int'(word)*32 +: 32];
                RK_MASK:    rd_d.rdata = mask_flat[int'(word)*32 +: 32];
                RK_DSTATE: begin
                    rd_d.rdata[ST_OFF_BIT]   = off_set[dom];
                    rd_d.rdata[ST_ON_BIT]    = on_set[dom];
                    rd_d.rdata[ST_GOOFF_BIT] = moving[dom] && !seq_dir_on;
                    rd_d.rdata[ST_GOON_BIT]  = moving[dom] && seq_dir_on;
                end
                RK_DERR:    rd_d.rdata[0] = err_vec[dom];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.rdata;
    assign pd_on = on_vec;

    p_start_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> $past(req_valid));

endmodule

// File: tb/sim_pdsc_top.sv
module sim_pdsc_top;

    localparam int N   = 64;
    localparam int SEQ = 8;

    logic        clk = 1'b0;
    logic        rst_n, wr_en, rd_en;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;
    logic [N-1:0] pd_on;

    always #4 clk = ~clk;

    pdsc_top #(.NUM_DOMAINS(N), .SEQ_CYCLES(SEQ), .ADDR_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .pd_on(pd_on)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_run  = 0;
    int   n_fail = 0;
    logic rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin : monitor
        exp_t e;
        if (rd_seen) begin
            n_run++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: got %h expected none", rdata);
            end else begin
                e = sb.pop_front();
                if (rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", e.tag, rdata, e.exp);
                end
            end
        end
    end

    function automatic logic [15:0] bank(input int n, input int off);
        return 16'(32'h1000 + n * 64 + off);
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        sb.push_back('{exp, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : driver
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state, R8 packed status words
        rd(16'h0000, 32'h3, "R1 ready at reset");
        rd(bank(0, 0), 32'h1, "R1 dom0 off");
        rd(bank(63, 0), 32'h1, "R1 dom63 off");
        rd(16'h0810, 32'h0, "R1 flags clear");
        rd(16'h0820, 32'h0, "R1 enables clear");
        rd(16'h0800, 32'h0, "R8 on word0 empty");
        rd(16'h080C, 32'hFFFF_FFFF, "R8 off word1 full");
        chk(32'(irq), 32'h0, "R1 irq low");
        chk(pd_on[31:0], 32'h0, "R1 pd_on low");

        wr(16'h0820, 32'hFFFF_FFFF);
        wr(16'h0824, 32'hFFFF_FFFF);
        rd(16'h0824, 32'hFFFF_FFFF, "R9 enable word1 readback");

        // R2 R4 R5 R6: power on dom3, refused request on dom5 mid-sequence
        wr(bank(3, 4), 32'h1);
        rd(16'h0000, 32'h0, "R2 busy after accept");
        rd(bank(3, 0), 32'h1000, "R4 on in progress");
        wr(bank(5, 4), 32'h1);
        rd(bank(5, 12), 32'h1, "R6 refused sets error");
        rd(bank(5, 0), 32'h1, "R6 refused domain unchanged");
        idle(2);
        rd(16'h0000, 32'h0, "R5 still busy last cycle");
        rd(16'h0000, 32'h3, "R5 ready after SEQ cycles");
        rd(bank(3, 0), 32'h10, "R4 R5 dom3 on");
        chk(32'(pd_on[3]), 32'h1, "R11 pd_on3 high");
        rd(16'h0810, 32'h8, "R9 flag dom3");
        rd(16'h0800, 32'h8, "R8 on word0");
        rd(16'h0808, 32'hFFFF_FFF7, "R8 off word0");
        chk(32'(irq), 32'h1, "R10 irq from flag");

        // R10 masking keeps flag
        wr(16'h0830, 32'h8);
        chk(32'(irq), 32'h0, "R10 masked irq low");
        rd(16'h0810, 32'h8, "R10 masked flag kept");
        wr(16'h0830, 32'h0);
        chk(32'(irq), 32'h1, "R10 unmask irq high");

        // R9 write-one-to-clear
        wr(16'h0810, 32'h0);
        rd(16'h0810, 32'h8, "R9 write zero no effect");
        wr(16'h0810, 32'h8);
        rd(16'h0810, 32'h0, "R9 W1C cleared");
        chk(32'(irq), 32'h0, "R10 irq low after clear");

        // R6 resubmit clears error
        wr(bank(5, 4), 32'h1);
        rd(bank(5, 12), 32'h0, "R6 accepted clears error");
        idle(7);
        rd(bank(5, 0), 32'h10, "R5 dom5 on");
        rd(16'h0810, 32'h20, "R9 flag dom5");

        // R7 request for current state
        wr(16'h0810, 32'h20);
        rd(16'h0810, 32'h0, "R9 dom5 flag cleared");
        wr(bank(5, 4), 32'h1);
        rd(16'h0000, 32'h3, "R7 no busy for same state");
        rd(16'h0810, 32'h20, "R7 immediate flag");

        // R9 enable gating, R11 power off
        wr(16'h0820, 32'h0);
        wr(16'h0810, 32'hFFFF_FFFF);
        wr(bank(3, 8), 32'h1);
        rd(bank(3, 0), 32'h100, "R4 off in progress");
        chk(32'(pd_on[3]), 32'h1, "R11 pd_on3 held during off");
        idle(7);
        rd(bank(3, 0), 32'h1, "R5 dom3 off");
        rd(16'h0810, 32'h0, "R9 disabled flag not recorded");
        chk(32'(pd_on[3]), 32'h0, "R11 pd_on3 low");
        chk(32'(irq), 32'h0, "R10 irq low");

        // R8 second word: domain 40
        wr(bank(40, 4), 32'h1);
        idle(9);
        rd(16'h0814, 32'h100, "R9 flag dom40 word1");
        rd(16'h0804, 32'h100, "R8 on word1");
        rd(16'h080C, 32'hFFFF_FEFF, "R8 off word1");
        chk(32'(irq), 32'h1, "R10 irq from word1");
        chk(32'(pd_on[40]), 32'h1, "R11 pd_on40 high");

        // R3 command with bit0 clear is ignored
        wr(bank(3, 4), 32'h2);
        rd(16'h0000, 32'h3, "R3 no start without bit0");
        rd(bank(3, 0), 32'h1, "R3 dom3 unchanged");

        idle(3);
        if (sb.size() != 0) begin
            n_run++;
            n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule